// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Control Logic

This block is the digital half of a serial 8-bit successive-approximation converter. A host reaches it through a four-wire slave port: an active-low select, a serial clock, a data input, and a data output that has its own enable. An 8-bit command word arrives on the data input. The first logic one after select goes low marks the start of the word. The word sets the input channel, the polarity, the input configuration, the power state and the clock source. After the last command bit the block holds the sample and runs eight binary-search decisions against an external comparator. It presents each trial code on `dac_code` and reads the answer on `cmp_hi`. It then shifts the result out MSB first.

The search can step on the host's serial-clock falling edges, or on ticks from a divider of the system clock. A strobe output reports progress, and it behaves differently for each clock source. A new command word may begin once the MSB of the current result is on the output. A steady stream therefore takes ten serial clocks per conversion. All serial inputs are brought into the system-clock domain through synchronisers, and edges are detected there.

Top module: `sar_serial_adc_if`

## Requirements
- R1: While select is low, zero bits on `din` before a start bit are ignored. The first one sampled on a rising serial edge becomes bit 7 of the command word, and the next seven rising edges fill bits 6 to 0.
- R2: The command word is loaded on the falling edge after bit 0 arrives. Bits 6:4 go to `chan_sel`. Bit 3 goes to `unipolar` (1 = unipolar). Bit 2 goes to `single_ended` (1 = single-ended). Bit 1 goes to `power_up` (1 = powered). Bit 0 goes to `ext_clk_mode` (1 = serial clock drives the search).
- R3: `dout` and `strobe` change only in response to falling serial edges, except for the strobe rise that ends an internally clocked conversion.
- R4: `track` rises on the falling edge after the sixth command bit and falls on the falling edge after the eighth.
- R5: The search starts with trial code 0x80. Each decision keeps the tested bit when `cmp_hi` is 1 and sets the next lower bit, so the result equals the largest code that the comparator reports as not above the sample.
- R6: With an external clock, `strobe` is high from the falling edge after the eighth command bit until the second falling edge after it. On that second edge it drops and the result MSB appears. The other seven bits follow on the next seven falling edges, and zeros follow after that.
- R7: With the internal clock, `strobe` goes low on the falling edge after the eighth command bit. It rises after eight ticks of CONV_DIV system clocks. `dout` is 0 on the first falling edge after the rise and carries the MSB on the second, followed by the other bits and then zeros.
- R8: While select is high, `dout_oe` is 0 and serial input is ignored. `strobe_oe` is 0 in external mode but stays 1 in internal mode, and an internal conversion keeps running.
- R9: A new start bit is accepted only after the current result MSB has been driven. One on `din` before then is ignored. A start bit on the rising edge right after the MSB lets the next conversion overlap readout, which gives ten clocks per conversion.
- R10: A rise of select re-arms start-bit detection even mid-conversion. The next command word then aborts the running conversion and starts a new one.
- R11: In unipolar mode the result is straight binary (the comparator code). In bipolar mode it is two's complement (the comparator code with bit 7 inverted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select of the serial port |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data input, sampled on rising serial edges |
| cmp_hi | input | 1 | Comparator answer: 1 when the sample is not below `dac_code` |
| dout | output | 1 | Serial data output value |
| dout_oe | output | 1 | Output enable for `dout` |
| strobe | output | 1 | Conversion strobe value |
| strobe_oe | output | 1 | Output enable for `strobe` |
| dac_code | output | 8 | Trial code presented to the comparator |
| track | output | 1 | High while the input is being tracked |
| chan_sel | output | 3 | Channel field of the last command word |
| unipolar | output | 1 | Polarity bit of the last command word |
| single_ended | output | 1 | Input configuration bit of the last command word |
| power_up | output | 1 | Power bit of the last command word |
| ext_clk_mode | output | 1 | Clock-source bit of the last command word |

## Verification
The bench sends command words after leading zeros. A framing error would shift every field, and this shows up as wrong control outputs and a wrong result. It places ones on `din` during the two strobe clocks. A design that accepts a start bit before the MSB would build a second word and break the first readout. It also runs a back-to-back stream at ten clocks per conversion, which shows a design that re-arms too late. Toggling select before the MSB catches a design that does not re-arm on the select rise, because its next word would be misframed. Raising select during an internal conversion catches a design that stops that conversion or releases the strobe.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        CV_IDLE,
        CV_EXT_WAIT,
        CV_EXT_BITS,
        CV_INT_RUN,
        CV_INT_DONE,
        CV_SHIFT
    } conv_state_e;

    typedef struct packed {
        logic [2:0] chan;
        logic       unipolar;
        logic       single_ended;
        logic       power_up;
        logic       ext_clk;
    } ctrl_t;

    typedef struct packed {
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] shr;
        logic              armed;
        logic              track;
    } rx_regs_t;

    typedef struct packed {
        conv_state_e       state;
        logic [BYTE_W-1:0] code;
        logic [BYTE_W-1:0] trial;
        logic [2:0]        idx;
        logic              phase;
        logic [BYTE_W-1:0] shr;
        logic              dout;
        logic              strb;
        logic              int_mode;
        ctrl_t             ctrl;
    } cv_regs_t;

    function automatic ctrl_t decode_ctrl(input logic [BYTE_W-2:0] b);
        ctrl_t c;
        c.chan         = b[6:4];
        c.unipolar     = b[3];
        c.single_ended = b[2];
        c.power_up     = b[1];
        c.ext_clk      = b[0];
        return c;
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= stage_d;
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sar_tick_div.sv
module sar_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run)               cnt_d = '0;
                else if (cnt_q == LAST) cnt_d = '0;
                else                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = run && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/sar_ctrl_rx.sv
module sar_ctrl_rx
    import sar_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              din_s,
    input  logic              arm_set,
    output logic              start_ev,
    output logic [BYTE_W-1:0] ctrl_byte,
    output logic              track
);
    localparam logic [3:0] FULL = 4'(BYTE_W);
    localparam logic [3:0] TRK  = 4'(BYTE_W - 2);

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        start_ev = 1'b0;
        if (!cs_act) begin
            r_d.cnt   = '0;
            r_d.track = 1'b0;
            r_d.armed = 1'b1;
        end else begin
            if (arm_set) r_d.armed = 1'b1;
            if (rise_ev) begin
                if (r_q.cnt == '0) begin
                    if (r_q.armed && din_s) begin
                        r_d.shr = {{(BYTE_W-1){1'b0}}, 1'b1};
                        r_d.cnt = 4'd1;
                    end
                end else if (r_q.cnt < FULL) begin
                    r_d.shr = {r_q.shr[BYTE_W-2:0], din_s};
                    r_d.cnt = r_q.cnt + 4'd1;
                end
            end
            if (fall_ev) begin
                if (r_q.cnt == TRK) r_d.track = 1'b1;
                if (r_q.cnt == FULL) begin
                    start_ev  = 1'b1;
                    r_d.track = 1'b0;
                    r_d.cnt   = '0;
                    r_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: '0, shr: '0, armed: 1'b1, track: 1'b0};
        else        r_q <= r_d;
    end

    assign ctrl_byte = r_q.shr;
    assign track     = r_q.track;

    AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cnt != '0) |-> (r_q.shr[r_q.cnt - 4'd1] == 1'b1 || r_q.cnt > 4'd1)); // R1
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_ev,
    input  logic              start_ev,
    input  logic [BYTE_W-2:0] ctrl_bits,
    input  logic              tick,
    input  logic              cmp_hi,
    output logic              dout,
    output logic              strb,
    output logic              int_mode,
    output logic              run,
    output logic              msb_out,
    output logic [BYTE_W-1:0] dac_code,
    output ctrl_t             ctrl
);
    localparam logic [BYTE_W-1:0] MID = {1'b1, {(BYTE_W-1){1'b0}}};

    cv_regs_t c_d, c_q;
    logic [BYTE_W-1:0] code_v, trial_v;

    always_comb begin
        code_v            = c_q.code;
        code_v[c_q.idx]   = cmp_hi;
        trial_v           = code_v;
        if (c_q.idx != 3'd0) trial_v[c_q.idx - 3'd1] = 1'b1;
    end

    always_comb begin
        c_d     = c_q;
        msb_out = 1'b0;
        if (start_ev) begin
            c_d.ctrl  = decode_ctrl(ctrl_bits);
            c_d.code  = '0;
            c_d.trial = MID;
            c_d.idx   = 3'd7;
            c_d.phase = 1'b0;
            c_d.dout  = 1'b0;
            c_d.shr   = '0;
            if (ctrl_bits[0]) begin
                c_d.state    = CV_EXT_WAIT;
                c_d.strb     = 1'b1;
                c_d.int_mode = 1'b0;
            end else begin
                c_d.state    = CV_INT_RUN;
                c_d.strb     = 1'b0;
                c_d.int_mode = 1'b1;
            end
        end else begin
            unique case (c_q.state)
                CV_EXT_WAIT: if (fall_ev) begin
                    if (!c_q.phase) begin
                        c_d.phase = 1'b1;
                    end else begin
                        c_d.code  = code_v;
                        c_d.trial = trial_v;
                        c_d.dout  = cmp_hi ^ ~c_q.ctrl.unipolar;
                        c_d.strb  = 1'b0;
                        c_d.idx   = c_q.idx - 3'd1;
                        c_d.state = CV_EXT_BITS;
                        msb_out   = 1'b1;
                    end
                end
                CV_EXT_BITS: if (fall_ev) begin
                    c_d.code  = code_v;
                    c_d.trial = trial_v;
                    c_d.dout  = cmp_hi;
                    if (c_q.idx == 3'd0) c_d.state = CV_SHIFT;
                    else                 c_d.idx   = c_q.idx - 3'd1;
                end
                CV_INT_RUN: if (tick) begin
                    c_d.code  = code_v;
                    c_d.trial = trial_v;
                    if (c_q.idx == 3'd0) begin
                        c_d.state = CV_INT_DONE;
                        c_d.strb  = 1'b1;
                        c_d.phase = 1'b0;
                        c_d.shr   = code_v ^ {~c_q.ctrl.unipolar, {(BYTE_W-1){1'b0}}};
                    end else begin
                        c_d.idx = c_q.idx - 3'd1;
                    end
                end
                CV_INT_DONE: if (fall_ev) begin
                    if (!c_q.phase) begin
                        c_d.phase = 1'b1;
                        c_d.dout  = 1'b0;
                    end else begin
                        c_d.dout  = c_q.shr[BYTE_W-1];
                        c_d.shr   = {c_q.shr[BYTE_W-2:0], 1'b0};
                        c_d.state = CV_SHIFT;
                        msb_out   = 1'b1;
                    end
                end
                CV_SHIFT: if (fall_ev) begin
                    c_d.dout = c_q.shr[BYTE_W-1];
                    c_d.shr  = {c_q.shr[BYTE_W-2:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign dout     = c_q.dout;
    assign strb     = c_q.strb;
    assign int_mode = c_q.int_mode;
    assign run      = (c_q.state == CV_INT_RUN);
    assign dac_code = c_q.trial;
    assign ctrl     = c_q.ctrl;

    AST_EXT_WAIT_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == CV_EXT_WAIT) |-> c_q.strb); // R6
    AST_INT_RUN_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == CV_INT_RUN) |-> (!c_q.strb && c_q.int_mode)); // R7
endmodule

// File: rtl/sar_serial_adc_if.sv
module sar_serial_adc_if
    import sar_if_pkg::*;
#(
    parameter int CONV_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              cmp_hi,
    output logic              dout,
    output logic              dout_oe,
    output logic              strobe,
    output logic              strobe_oe,
    output logic [BYTE_W-1:0] dac_code,
    output logic              track,
    output logic [2:0]        chan_sel,
    output logic              unipolar,
    output logic              single_ended,
    output logic              power_up,
    output logic              ext_clk_mode
);
    logic [2:0] sync_q;
    logic cs_act, sclk_s, din_s;
    logic sclk_d, sclk_q;
    logic rise_ev, fall_ev;
    logic start_ev, arm_set, tick, run, int_mode;
    logic [BYTE_W-1:0] ctrl_byte;
    ctrl_t ctrl;

    sar_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(sync_q));

    assign cs_act = ~sync_q[2];
    assign sclk_s = sync_q[1];
    assign din_s  = sync_q[0];

    always_comb sclk_d = sclk_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

    assign rise_ev = cs_act &  sclk_s & ~sclk_q;
    assign fall_ev = cs_act & ~sclk_s &  sclk_q;

    sar_ctrl_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise_ev(rise_ev),
        .fall_ev(fall_ev), .din_s(din_s), .arm_set(arm_set),
        .start_ev(start_ev), .ctrl_byte(ctrl_byte), .track(track));

    sar_tick_div #(.DIV(CONV_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

    sar_conv_seq u_conv (
        .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .start_ev(start_ev),
        .ctrl_bits(ctrl_byte[BYTE_W-2:0]), .tick(tick), .cmp_hi(cmp_hi),
        .dout(dout), .strb(strobe), .int_mode(int_mode), .run(run),
        .msb_out(arm_set), .dac_code(dac_code), .ctrl(ctrl));

    assign dout_oe      = cs_act;
    assign strobe_oe    = cs_act | int_mode;
    assign chan_sel     = ctrl.chan;
    assign unipolar     = ctrl.unipolar;
    assign single_ended = ctrl.single_ended;
    assign power_up     = ctrl.power_up;
    assign ext_clk_mode = ctrl.ext_clk;

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(dout) |-> $past(fall_ev)); // R3
    AST_STRB_EDGE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(strobe) |-> $past(fall_ev || tick)); // R3
    AST_HOLD_LOADS_MID: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(track) && $past(cs_act)) |-> (dac_code == 8'h80)); // R4
    AST_INT_NO_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe) && int_mode) |-> $past(tick)); // R7
endmodule

// File: tb/sar_serial_adc_if_test.sv
module sar_serial_adc_if_test;
    localparam int DIV_T = 4;
    localparam logic [15:0] EXT_VEC [5] = '{16'hFF_A5, 16'h8B_00, 16'hF3_3C,
                                            16'hCF_FF, 16'hC3_80};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [7:0] sample = 8'h00;
    logic cmp_hi;
    logic dout, dout_oe, strobe, strobe_oe, track;
    logic [7:0] dac_code;
    logic [2:0] chan_sel;
    logic unipolar, single_ended, power_up, ext_clk_mode;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    assign cmp_hi = (sample >= dac_code);

    sar_serial_adc_if #(.CONV_DIV(DIV_T), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cmp_hi(cmp_hi), .dout(dout), .dout_oe(dout_oe), .strobe(strobe),
        .strobe_oe(strobe_oe), .dac_code(dac_code), .track(track),
        .chan_sel(chan_sel), .unipolar(unipolar), .single_ended(single_ended),
        .power_up(power_up), .ext_clk_mode(ext_clk_mode));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rise_half(input logic d);
        @(negedge clk); din = d;
        waitc(4); sclk = 1'b1;
        waitc(8);
    endtask

    task automatic fall_half();
        sclk = 1'b0;
        waitc(8);
    endtask

    // R3: every sample is taken well after the falling edge it depends on
    task automatic clk_bit(input logic d);
        rise_half(d);
        fall_half();
    endtask

    function automatic logic [7:0] expect_code(input logic [7:0] cb, input logic [7:0] s);
        return cb[3] ? s : (s ^ 8'h80);
    endfunction

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i]);
            if (i == 2) chk("R4 track after sixth bit", track, 1'b1);
        end
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0);
            v[i] = dout;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired (R1..R11 incomplete)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, cb, b2;
        waitc(5);
        chk("R8 reset dout_oe", dout_oe, 1'b0);
        chk("R8 reset strobe_oe", strobe_oe, 1'b0);
        chk("R5 reset dac_code", dac_code, 8'h00);
        chk("R4 reset track", track, 1'b0);
        rst_n = 1'b1;
        waitc(5);

        // table walk: external-clock conversions
        for (int v = 0; v < 5; v++) begin
            cb = EXT_VEC[v][15:8];
            sample = EXT_VEC[v][7:0];
            cs_n = 1'b0; waitc(6);
            chk("R8 dout_oe with select low", dout_oe, 1'b1);
            clk_bit(1'b0); clk_bit(1'b0);           // R1 leading zeros
            chk("R1 leading zeros start nothing", strobe, 1'b0);
            send_byte(cb);
            chk("R2 fields", {chan_sel, unipolar, single_ended, power_up, ext_clk_mode}, cb[6:0]);
            chk("R6 strobe high at hold", strobe, 1'b1);
            chk("R4 track low at hold", track, 1'b0);
            chk("R5 first trial", dac_code, 8'h80);
            clk_bit(1'b0);
            chk("R6 strobe second period", strobe, 1'b1);
            for (int i = 7; i >= 0; i--) begin
                clk_bit(1'b0);
                r[i] = dout;
                if (i == 7) begin
                    chk("R6 strobe low at MSB", strobe, 1'b0);
                    rise_half(1'b0);
                    chk("R3 dout holds across rising edge", dout, r[7]);
                    fall_half();
                    r[6] = dout;
                    i--;
                end
            end
            chk("R5 R11 external result", r, expect_code(cb, sample));
            clk_bit(1'b0);
            chk("R6 zeros after result", dout, 1'b0);
            cs_n = 1'b1; waitc(6);
            chk("R8 dout_oe released", dout_oe, 1'b0);
            chk("R8 strobe_oe released in external mode", strobe_oe, 1'b0);
        end

        // R9: ones before MSB ignored, then ten-clock overlap
        sample = 8'h6D;
        cs_n = 1'b0; waitc(6);
        send_byte(8'h8F);
        clk_bit(1'b1);
        chk("R9 strobe still high", strobe, 1'b1);
        clk_bit(1'b1);
        r[7] = dout;
        chk("R9 early one ignored, strobe low", strobe, 1'b0);
        b2 = 8'hF7;
        for (int k = 0; k < 8; k++) begin
            clk_bit(b2[7-k]);
            if (k < 7) r[6-k] = dout;
            if (k == 6) sample = 8'h22;
        end
        chk("R9 first result during overlap", r, 8'h6D);
        chk("R9 second word accepted", strobe, 1'b1);
        chk("R2 second word fields", {chan_sel, unipolar}, 4'b1110);
        clk_bit(1'b0);
        read_byte(r);
        chk("R11 bipolar overlap result", r, 8'hA2);
        cs_n = 1'b1; waitc(6);

        // R10: select toggle before MSB re-arms and aborts
        sample = 8'h44;
        cs_n = 1'b0; waitc(6);
        send_byte(8'h9F);
        clk_bit(1'b0);
        cs_n = 1'b1; waitc(10);
        cs_n = 1'b0; waitc(10);
        sample = 8'hC3;
        send_byte(8'hBB);
        chk("R10 new word after toggle", chan_sel, 3'd3);
        chk("R10 new conversion strobe", strobe, 1'b1);
        clk_bit(1'b0);
        read_byte(r);
        chk("R10 new result", r, 8'hC3);
        cs_n = 1'b1; waitc(6);

        // R8: input ignored with select high
        for (int i = 0; i < 10; i++) clk_bit(1'b1);
        chk("R8 no tracking with select high", track, 1'b0);
        chk("R8 fields unchanged", chan_sel, 3'd3);
        cs_n = 1'b0; waitc(6);
        chk("R8 nothing started", strobe, 1'b0);
        cs_n = 1'b1; waitc(6);

        // R7: internal-clock conversions
        for (int t = 0; t < 2; t++) begin
            cb = (t == 0) ? 8'hAE : 8'h86;
            sample = (t == 0) ? 8'h5B : 8'h10;
            cs_n = 1'b0; waitc(6);
            send_byte(cb);
            chk("R7 strobe low at start", strobe, 1'b0);
            chk("R2 internal fields", {chan_sel, ext_clk_mode}, {cb[6:4], 1'b0});
            cs_n = 1'b1; waitc(4);
            chk("R8 dout_oe off during internal run", dout_oe, 1'b0);
            chk("R8 strobe still driven", strobe_oe, 1'b1);
            waitc(4 * DIV_T - 12);
            chk("R7 strobe low mid conversion", strobe, 1'b0);
            waitc(8 * DIV_T);
            chk("R7 strobe high after ticks", strobe, 1'b1);
            cs_n = 1'b0; waitc(6);
            clk_bit(1'b0);
            chk("R7 first fall gives zero", dout, 1'b0);
            read_byte(r);
            chk("R7 R11 internal result", r, expect_code(cb, sample));
            clk_bit(1'b0);
            chk("R7 zeros after result", dout, 1'b0);
            cs_n = 1'b1; waitc(6);
        end

        // reset mid-session
        rst_n = 1'b0; waitc(3);
        chk("R5 reset clears trial", dac_code, 8'h00);
        chk("R8 reset strobe_oe", strobe_oe, 1'b0);
        chk("R2 reset fields", {chan_sel, unipolar, single_ended, power_up, ext_clk_mode}, 7'h00);
        rst_n = 1'b1; waitc(3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule